// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

A bank of hardware semaphores that processors on a shared chip use to serialise access to common resources. Every semaphore is one word register on a simple single-cycle register bus. The bank has several bus ports, one per master. Each port carries an address, write data, write enable, read enable, read data, and a master-ID sideband.

To claim a semaphore, a master writes its own nonzero ID into the semaphore's register. It then reads the register back. The claim is won only if the low nibble equals its ID. A write whose low nibble is zero is a release. It takes effect only when the writing port's sideband ID matches the stored owner. When several masters claim the same free semaphore in one cycle, the lowest port index wins.

The bank also has a one-bit protocol-select control word at offset 0x00. A write-only interrupt-clear word sits at 0x90. This bank generates no interrupts, so a write there changes nothing.

Top module: `hw_sem_bank`

## Requirements
- R1: After reset, every semaphore reads 0 (free) and the control word reads 0.
- R2: Semaphore n lives at byte offset 0x08 + 4*n (n = 0..31). A read returns the owner ID in bits [3:0] and zeros in bits [31:4]. The read data is combinational in the same cycle. Read data is 0 on any port whose read enable is low.
- R3: A write with a nonzero low nibble to a free semaphore stores that nibble as the owner. The new owner is visible from the next cycle.
- R4: A write with a nonzero low nibble to a held semaphore leaves the stored owner unchanged.
- R5: A write with a zero low nibble frees a held semaphore only if that port's master-ID sideband equals the stored owner. Otherwise it is ignored.
- R6: When several ports claim the same free semaphore in one cycle, the port with the lowest index becomes owner.
- R7: The control word at 0x00 stores write-data bit 0 and reads it back in bit 0, with all other bits 0. On simultaneous writes, the lowest port index wins.
- R8: Offset 0x90 reads 0, and a write to it (for example 0xFFFF) changes no semaphore and not the control word.
- R9: Reads of unmapped or non-word-aligned offsets (including 0x88, 0x8C, 0x94 and above) return 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | NUM_MST*8 | Byte address per port |
| wdata_i | input | NUM_MST*32 | Write data per port |
| we_i | input | NUM_MST | Write enable per port |
| re_i | input | NUM_MST | Read enable per port |
| mid_i | input | NUM_MST*4 | Master-ID sideband per port, used for release |
| rdata_o | output | NUM_MST*32 | Read data per port, combinational |

## Verification
The hardest situation to reach is contention: several ports claiming, releasing and re-claiming the same semaphore in the same cycle. A foreign release also has to land on a held semaphore while its owner is idle. The random phase confines most semaphore traffic to four indices shared by three ports. Each cycle, every port draws a read, claim, release, control or stray access. Same-cycle collisions therefore happen often, and the bench's reference model resolves them by port priority. Directed cycles cover the exact three-way claim, the foreign release, the last semaphore, the boundary offsets 0x84/0x88/0x90, and misaligned addresses.

// File: rtl/hw_sem_pkg.sv
package hw_sem_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ID_W    = 4;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h00;
  localparam logic [ADDR_W-1:0] SEM_BASE = 8'h08;
  localparam logic [ADDR_W-1:0] CLR_OFS  = 8'h90;

  typedef struct packed {
    logic ctrl;
    logic clr;
    logic sem;
  } hit_t;
endpackage

// File: rtl/sem_addr_decode.sv
module sem_addr_decode
  import hw_sem_pkg::*;
#(
  parameter int unsigned NUM_SEM = 32
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output hit_t               hit_o,
  output logic [NUM_SEM-1:0] sem_sel_o
);
  localparam int unsigned WORD_W    = ADDR_W - 2;
  localparam int unsigned SEM_FIRST = int'(SEM_BASE) / 4;
  localparam int unsigned SEM_LAST  = SEM_FIRST + NUM_SEM - 1;

  logic              aligned;
  logic [WORD_W-1:0] word;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign word    = addr_i[ADDR_W-1:2];

  always_comb begin
    hit_o.ctrl = aligned && (addr_i == CTRL_OFS);
    hit_o.clr  = aligned && (addr_i == CLR_OFS);
    hit_o.sem  = aligned && (int'(word) >= int'(SEM_FIRST)) && (int'(word) <= int'(SEM_LAST));
  end

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_sel
    assign sem_sel_o[s] = hit_o.sem && (int'(word) == int'(SEM_FIRST) + s);
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import hw_sem_pkg::*;
#(
  parameter int unsigned NUM_MST = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_MST-1:0]            claim_i,
  input  logic [NUM_MST-1:0]            rel_i,
  input  logic [NUM_MST-1:0][ID_W-1:0]  wid_i,
  input  logic [NUM_MST-1:0][ID_W-1:0]  mid_i,
  output logic [ID_W-1:0]               owner_o
);
  logic [ID_W-1:0] owner_q, owner_d;

  always_comb begin
    owner_d = owner_q;
    if (owner_q == '0) begin
      // descending scan: lowest index written last, so it wins
      for (int m = NUM_MST - 1; m >= 0; m--) begin
        if (claim_i[m]) owner_d = wid_i[m];
      end
    end else begin
      for (int m = 0; m < NUM_MST; m++) begin
        if (rel_i[m] && (mid_i[m] == owner_q)) owner_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= '0;
    else         owner_q <= owner_d;
  end

  assign owner_o = owner_q;

  // R4
  held_no_steal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o != '0) |=> (owner_o == $past(owner_o) || owner_o == '0));

  // R5
  no_rel_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o != '0 && rel_i == '0) |=> $stable(owner_o));

  // R3
  idle_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o == '0 && claim_i == '0) |=> (owner_o == '0));

  // R6
  low_port_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o == '0 && claim_i[0]) |=> (owner_o == $past(wid_i[0])));
endmodule

// File: rtl/sem_rd_mux.sv
module sem_rd_mux
  import hw_sem_pkg::*;
#(
  parameter int unsigned NUM_SEM = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         re_i,
  input  hit_t                         hit_i,
  input  logic [NUM_SEM-1:0]           sem_sel_i,
  input  logic [NUM_SEM-1:0][ID_W-1:0] owner_i,
  input  logic                         ctrl_i,
  output logic [DATA_W-1:0]            rdata_o
);
  logic [ID_W-1:0] sem_val;

  always_comb begin
    sem_val = '0;
    for (int s = 0; s < NUM_SEM; s++) begin
      if (sem_sel_i[s]) sem_val = sem_val | owner_i[s];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (hit_i.sem)       rdata_o[ID_W-1:0] = sem_val;
      else if (hit_i.ctrl) rdata_o[0]        = ctrl_i;
    end
  end

  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i.sem && !hit_i.ctrl) |-> (rdata_o == '0));

  // R2
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:ID_W] == '0);

  // R2
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> (rdata_o == '0));
endmodule

// File: rtl/hw_sem_bank.sv
module hw_sem_bank
  import hw_sem_pkg::*;
#(
  parameter int unsigned NUM_MST = 3,
  parameter int unsigned NUM_SEM = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_MST-1:0][ADDR_W-1:0] addr_i,
  input  logic [NUM_MST-1:0][DATA_W-1:0] wdata_i,
  input  logic [NUM_MST-1:0]             we_i,
  input  logic [NUM_MST-1:0]             re_i,
  input  logic [NUM_MST-1:0][ID_W-1:0]   mid_i,
  output logic [NUM_MST-1:0][DATA_W-1:0] rdata_o
);
  hit_t [NUM_MST-1:0]               hit;
  logic [NUM_MST-1:0][NUM_SEM-1:0]  sel;
  logic [NUM_SEM-1:0][NUM_MST-1:0]  claim, rel;
  logic [NUM_MST-1:0][ID_W-1:0]     wid;
  logic [NUM_SEM-1:0][ID_W-1:0]     owner;
  logic                             ctrl_q, ctrl_d;
  logic [NUM_MST-1:0]               ctrl_we;

  for (genvar m = 0; m < NUM_MST; m++) begin : g_port
    sem_addr_decode #(.NUM_SEM(NUM_SEM)) u_dec (
      .addr_i    (addr_i[m]),
      .hit_o     (hit[m]),
      .sem_sel_o (sel[m])
    );

    assign wid[m]     = wdata_i[m][ID_W-1:0];
    assign ctrl_we[m] = we_i[m] && hit[m].ctrl;

    sem_rd_mux #(.NUM_SEM(NUM_SEM)) u_rd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .re_i      (re_i[m]),
      .hit_i     (hit[m]),
      .sem_sel_i (sel[m]),
      .owner_i   (owner),
      .ctrl_i    (ctrl_q),
      .rdata_o   (rdata_o[m])
    );
  end

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
    for (genvar m = 0; m < NUM_MST; m++) begin : g_req
      assign claim[s][m] = we_i[m] && sel[m][s] && (wid[m] != '0);
      assign rel[s][m]   = we_i[m] && sel[m][s] && (wid[m] == '0);
    end

    sem_cell #(.NUM_MST(NUM_MST)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .claim_i (claim[s]),
      .rel_i   (rel[s]),
      .wid_i   (wid),
      .mid_i   (mid_i),
      .owner_o (owner[s])
    );
  end

  always_comb begin
    ctrl_d = ctrl_q;
    for (int m = NUM_MST - 1; m >= 0; m--) begin
      if (ctrl_we[m]) ctrl_d = wdata_i[m][0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= 1'b0;
    else         ctrl_q <= ctrl_d;
  end

  // R7
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we == '0) |=> $stable(ctrl_q));

  // R7
  ctrl_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we[0] |=> (ctrl_q == $past(wdata_i[0][0])));
endmodule

// File: tb/tb_hw_sem_bank.sv
`timescale 1ns/1ps
module tb_hw_sem_bank;
  localparam int NM = 3;
  localparam int NS = 32;

  logic clk_i = 0, rst_ni = 0;
  logic [NM-1:0][7:0]  addr_i;
  logic [NM-1:0][31:0] wdata_i;
  logic [NM-1:0]       we_i, re_i;
  logic [NM-1:0][3:0]  mid_i;
  logic [NM-1:0][31:0] rdata_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] m_own [NS];
  logic       m_ctrl;

  hw_sem_bank #(.NUM_MST(NM), .NUM_SEM(NS)) dut (.*);

  always #2.5 clk_i = ~clk_i;

  function automatic int sem_idx(input logic [7:0] a);
    if (a[1:0] != 0) return -1;
    if (a >= 8'h08 && a <= 8'h08 + 4*(NS-1)) return (int'(a) - 8) / 4;
    return -1;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    int s = sem_idx(a);
    if (s >= 0) return {28'b0, m_own[s]};
    if (a == 8'h00) return {31'b0, m_ctrl};
    return 32'b0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    for (int m = 0; m < NM; m++) begin
      addr_i[m] = 0; wdata_i[m] = 0; we_i[m] = 0; re_i[m] = 0;
    end
  endtask

  // check reads before the edge, then advance the model with the same inputs
  task automatic cycle(input string tag);
    #1;
    for (int m = 0; m < NM; m++)
      chk(tag, rdata_o[m], re_i[m] ? exp_rd(addr_i[m]) : 32'b0);
    @(posedge clk_i);
    for (int m = NM - 1; m >= 0; m--)
      if (we_i[m] && addr_i[m] == 8'h00) m_ctrl = wdata_i[m][0];
    for (int s = 0; s < NS; s++) begin
      if (m_own[s] == 0) begin
        for (int m = NM - 1; m >= 0; m--)
          if (we_i[m] && sem_idx(addr_i[m]) == s && wdata_i[m][3:0] != 0)
            m_own[s] = wdata_i[m][3:0];
      end else begin
        logic [3:0] cur = m_own[s];
        for (int m = 0; m < NM; m++)
          if (we_i[m] && sem_idx(addr_i[m]) == s && wdata_i[m][3:0] == 0 && mid_i[m] == cur)
            m_own[s] = 0;
      end
    end
    @(negedge clk_i);
    idle();
  endtask

  task automatic set_op(input int m, input logic [7:0] a, input logic [31:0] d,
                        input logic w, input logic r);
    addr_i[m] = a; wdata_i[m] = d; we_i[m] = w; re_i[m] = r;
  endtask

  function automatic logic [7:0] sa(input int s);
    return 8'(8 + 4*s);
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5e3a));
    for (int m = 0; m < NM; m++) mid_i[m] = 4'(m + 1);
    idle();
    for (int s = 0; s < NS; s++) m_own[s] = 0;
    m_ctrl = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state, R2 full map readback
    for (int s = 0; s < NS; s += NM) begin
      for (int m = 0; m < NM; m++)
        if (s + m < NS) set_op(m, sa(s + m), 0, 0, 1);
      cycle("R1_R2");
    end
    set_op(0, 8'h00, 0, 0, 1);
    cycle("R1");

    // R6 three-way claim on sem 5: port 0 (id 1) wins
    for (int m = 0; m < NM; m++) set_op(m, sa(5), 32'(m + 1), 1, 0);
    cycle("R6");
    set_op(2, sa(5), 0, 0, 1);
    cycle("R6");
    chk("R6", {28'b0, m_own[5]}, 32'd1);

    // R4 claim on held sem; R5 foreign release ignored
    set_op(1, sa(5), 2, 1, 0);
    set_op(2, sa(5), 0, 1, 0);
    cycle("R4_R5");
    set_op(0, sa(5), 0, 0, 1);
    cycle("R4_R5");
    // R5 owner release
    set_op(0, sa(5), 32'hFFFF_FFF0, 1, 0);
    cycle("R5");
    set_op(1, sa(5), 0, 0, 1);
    cycle("R5");

    // R3 last semaphore, upper bits of claim data dropped
    set_op(2, sa(NS - 1), 32'hABCD_1233, 1, 0);
    cycle("R3");
    set_op(2, sa(NS - 1), 0, 0, 1);
    cycle("R3");

    // R7 control write/readback, priority
    set_op(1, 8'h00, 32'hFFFF_FFFF, 1, 0);
    set_op(2, 8'h00, 32'h0, 1, 0);
    cycle("R7");
    set_op(0, 8'h00, 0, 0, 1);
    cycle("R7");

    // R8 clear word; R9 unmapped and misaligned
    set_op(0, 8'h90, 32'hFFFF, 1, 1);
    set_op(1, 8'h88, 32'h7, 1, 1);
    set_op(2, 8'h09, 32'h3, 1, 1);
    cycle("R8_R9");
    set_op(0, sa(0), 0, 0, 1);
    set_op(1, 8'h8C, 0, 0, 1);
    set_op(2, 8'h00, 0, 0, 1);
    cycle("R8_R9");
    set_op(0, 8'h90, 0, 0, 1);
    set_op(1, sa(NS - 1), 0, 0, 1);
    set_op(2, 8'hFC, 0, 0, 1);
    cycle("R8_R9");

    // random contention on sems 0..3
    for (int i = 0; i < 4000; i++) begin
      for (int m = 0; m < NM; m++) begin
        int op = $urandom % 8;
        int s = ($urandom % 8 == 0) ? int'($urandom % NS) : int'($urandom % 4);
        case (op)
          0, 1, 2: set_op(m, sa(s), 0, 0, 1);
          3, 4:    set_op(m, sa(s), 32'(m + 1), 1, $urandom % 2);
          5:       set_op(m, sa(s), 32'($urandom) & 32'hFFFF_FFF0, 1, 1);
          6:       set_op(m, 8'h00, 32'($urandom), $urandom % 2, 1);
          default: set_op(m, 8'($urandom), 32'($urandom), $urandom % 2, $urandom % 2);
        endcase
      end
      cycle("R2_R3_R4_R5_R6_R7_R9");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule